// File: doc/BRIEF.md
# Watchdog Timer with Delayed System Reset

This block guards a system against stalled software. A counter advances on every cycle in which the slow watchdog clock enable is high. When the counter reaches the selected period, the block reports a time-out. Software keeps the system alive by issuing a restart command before the period runs out. A time-out always sets a sticky interrupt flag.

Software can also choose reset mode. In that mode a time-out starts a second, shorter window of selectable length. If software does not restart the watchdog before this window closes, the block emits a one-cycle system reset pulse and returns to its initial state.

A configuration input can hold the watchdog permanently enabled, so that software cannot switch it off. A time-out that occurs while the system reports a low-power state also raises a one-cycle wake-up request.

Top module: `wdt_guard`

## Requirements
- R1: After `rst_n` is released, `irq`, `rst_pulse` and `wake_req` are all low.
- R2: The counter advances on each rising `clk` edge where `wclk_en` is high and the watchdog is enabled. The time-out happens on the P-th such edge after a restart. P is 2^(4+2k) for `period_sel` = k, with k from 0 to 8. Any `period_sel` value from 9 to 15 selects the longest period, 2^20.
- R3: A time-out sets `irq`, and `irq` stays high until it is cleared. Holding `irq_clr` high for one cycle clears `irq`. If a time-out and `irq_clr` fall on the same edge, the time-out wins.
- R4: While `rst_en` is low, no reset pulse is ever produced.
- R5: While `rst_en` is high, a time-out opens a delay window of D enabled ticks. `dly_sel` 0 gives D = 1026, 1 gives 130, 2 gives 18 and 3 gives 3. `rst_pulse` is emitted on the D-th tick after the time-out edge and is high for exactly one cycle.
- R6: The edge that emits the reset pulse also clears `irq` and zeroes the counter. The next time-out therefore comes P ticks after that edge.
- R7: A `restart` cycle zeroes the counter and drops a pending delay window. A time-out that occurs while a window is already open does not restart that window.
- R8: The watchdog runs only while `en` or `force_on` is high, and `force_on` overrides `en` low. While the watchdog is not running, the counter is held at zero and any open delay window is dropped.
- R9: A time-out that occurs while `sleep` is high raises `wake_req` for one cycle, on the same edge that sets `irq`.
- R10: If `period_sel` is lowered to a period at or below the current count, the time-out happens on the next enabled tick.
- R11: Edges where `wclk_en` is low do not advance the counter or the delay window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk_en | input | 1 | Watchdog tick; the counter advances only when this is high |
| en | input | 1 | Software enable |
| force_on | input | 1 | Configuration input that keeps the watchdog enabled regardless of `en` |
| period_sel | input | 4 | Time-out period select |
| rst_en | input | 1 | High selects time-out followed by delayed reset; low selects interrupt only |
| dly_sel | input | 2 | Reset delay window select |
| restart | input | 1 | Restart command: zeroes the counter and the delay window |
| irq_clr | input | 1 | Clears the sticky time-out flag |
| sleep | input | 1 | Low-power state indication |
| irq | output | 1 | Sticky time-out interrupt |
| rst_pulse | output | 1 | One-cycle system reset request |
| wake_req | output | 1 | One-cycle wake-up request |

## Verification
The assertions check cycle-local properties on every cycle:
- the reset pulse is one cycle wide, needs reset mode, and clears the interrupt;
- no reset pulse follows a restart cycle;
- the interrupt rises only on an enabled tick;
- a wake request comes only from sleep and always with the interrupt set.

Only the bench scenarios can show the exact time-out edges. These cover the period taps, the four delay lengths, a restart inside an open window, a shortened period, the half-rate tick and the disabled or forced-on cases. The bench compares each expected event edge against the edge at which the design produces that event.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

   // State of the post time-out reset window
   typedef enum logic {
      DLY_IDLE = 1'b0,
      DLY_RUN  = 1'b1
   } dly_state_e;

   // Number of selectable reset delay lengths
   localparam int unsigned DLY_CHOICES = 4;

   // Bit width that can hold a count up to and including val
   function automatic int unsigned bits_for(input int unsigned val);
      int unsigned w;
      w = 1;
      while ((64'd1 << w) <= 64'(val)) w++;
      return w;
   endfunction

endpackage

// File: rtl/wdt_guard_period_cnt.sv
module wdt_guard_period_cnt #(
   parameter int unsigned CNT_W     = 20,
   parameter int unsigned N_PERIODS = 9,
   parameter int unsigned TAP_LO    = 4,
   parameter int unsigned TAP_STEP  = 2,
   parameter int unsigned SEL_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic             clear,
   input  logic [SEL_W-1:0] sel,
   output logic             timeout
);

   logic [CNT_W-1:0] lim_tab [N_PERIODS];
   logic [CNT_W-1:0] lim;
   logic [CNT_W-1:0] cnt;
   logic             hit;

   // Terminal count of each period: 2^(TAP_LO + TAP_STEP*g) - 1
   for (genvar g = 0; g < N_PERIODS; g++) begin : g_lim
      localparam int unsigned EXPO = TAP_LO + TAP_STEP * g;
      assign lim_tab[g] = CNT_W'((64'd1 << EXPO) - 64'd1);
   end

   // Out-of-range selects fall back to the longest period
   always_comb begin
      lim = lim_tab[N_PERIODS-1];
      for (int i = 0; i < N_PERIODS; i++) begin
         if (sel == SEL_W'(i)) lim = lim_tab[i];
      end
   end

   // >= so that a shortened period fires on the next tick
   assign hit     = run & tick & ~clear & (cnt >= lim);
   assign timeout = hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear || !run) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= hit ? '0 : cnt + 1'b1;
      end
   end

endmodule

// File: rtl/wdt_guard_rst_dly.sv
module wdt_guard_rst_dly
   import wdt_guard_pkg::*;
#(
   parameter int unsigned DLY_W = 11,
   parameter int unsigned DLY0  = 1026,
   parameter int unsigned DLY1  = 130,
   parameter int unsigned DLY2  = 18,
   parameter int unsigned DLY3  = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       clear,
   input  logic       start,
   input  logic [1:0] code,
   output logic       fire
);

   localparam logic [DLY_W-1:0] LEN [DLY_CHOICES] = '{
      DLY_W'(DLY0), DLY_W'(DLY1), DLY_W'(DLY2), DLY_W'(DLY3)
   };

   dly_state_e       st;
   logic [DLY_W-1:0] dcnt;
   logic [DLY_W-1:0] last;

   assign last = LEN[code] - 1'b1;
   assign fire = (st == DLY_RUN) & tick & ~clear & (dcnt >= last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= DLY_IDLE;
         dcnt <= '0;
      end else if (clear || fire) begin
         st   <= DLY_IDLE;
         dcnt <= '0;
      end else if (st == DLY_RUN) begin
         if (tick) dcnt <= dcnt + 1'b1;
      end else if (start) begin
         st   <= DLY_RUN;
         dcnt <= '0;
      end
   end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdt_guard_pkg::*;
#(
   parameter int unsigned CNT_W     = 20,
   parameter int unsigned N_PERIODS = 9,
   parameter int unsigned TAP_LO    = 4,
   parameter int unsigned TAP_STEP  = 2,
   parameter int unsigned DLY0      = 1026,
   parameter int unsigned DLY1      = 130,
   parameter int unsigned DLY2      = 18,
   parameter int unsigned DLY3      = 3,
   parameter bit          HAS_RESET = 1'b1,
   localparam int unsigned SEL_W    = bits_for(N_PERIODS - 1),
   localparam int unsigned DLY_MAX  = (DLY0 > DLY1 ? DLY0 : DLY1) > (DLY2 > DLY3 ? DLY2 : DLY3)
                                    ? (DLY0 > DLY1 ? DLY0 : DLY1) : (DLY2 > DLY3 ? DLY2 : DLY3),
   localparam int unsigned DLY_W    = bits_for(DLY_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wclk_en,
   input  logic             en,
   input  logic             force_on,
   input  logic [SEL_W-1:0] period_sel,
   input  logic             rst_en,
   input  logic [1:0]       dly_sel,
   input  logic             restart,
   input  logic             irq_clr,
   input  logic             sleep,
   output logic             irq,
   output logic             rst_pulse,
   output logic             wake_req
);

   // Elaboration-time parameter checks
   if (N_PERIODS < 2) begin : g_bad_n
      $error("wdt_guard: N_PERIODS must be at least 2");
   end
   if (TAP_LO + TAP_STEP * (N_PERIODS - 1) > CNT_W) begin : g_bad_tap
      $error("wdt_guard: longest period does not fit in CNT_W");
   end
   if (DLY0 == 0 || DLY1 == 0 || DLY2 == 0 || DLY3 == 0) begin : g_bad_dly
      $error("wdt_guard: delay lengths must be non-zero");
   end

   logic run;
   logic timeout;
   logic fire;
   logic flag_q;
   logic rst_q;
   logic wake_q;

   assign run = en | force_on;

   wdt_guard_period_cnt #(
      .CNT_W     (CNT_W),
      .N_PERIODS (N_PERIODS),
      .TAP_LO    (TAP_LO),
      .TAP_STEP  (TAP_STEP),
      .SEL_W     (SEL_W)
   ) u_period (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (wclk_en),
      .run     (run),
      .clear   (restart | fire),
      .sel     (period_sel),
      .timeout (timeout)
   );

   if (HAS_RESET) begin : g_rst
      wdt_guard_rst_dly #(
         .DLY_W (DLY_W),
         .DLY0  (DLY0),
         .DLY1  (DLY1),
         .DLY2  (DLY2),
         .DLY3  (DLY3)
      ) u_dly (
         .clk   (clk),
         .rst_n (rst_n),
         .tick  (wclk_en),
         .clear (restart | ~run | ~rst_en),
         .start (timeout & rst_en),
         .code  (dly_sel),
         .fire  (fire)
      );
   end else begin : g_norst
      assign fire = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         rst_q  <= 1'b0;
         wake_q <= 1'b0;
      end else begin
         rst_q  <= fire;
         wake_q <= timeout & sleep;
         if (fire)         flag_q <= 1'b0;
         else if (timeout) flag_q <= 1'b1;
         else if (irq_clr) flag_q <= 1'b0;
      end
   end

   assign irq       = flag_q;
   assign rst_pulse = rst_q;
   assign wake_req  = wake_q;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic wclk_en,
   input logic en,
   input logic force_on,
   input logic rst_en,
   input logic restart,
   input logic sleep,
   input logic irq,
   input logic rst_pulse,
   input logic wake_req
);

   // R5
   rst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |=> !rst_pulse);

   // R4
   rst_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> $past(rst_en));

   // R6
   rst_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> !irq);

   // R7
   restart_blocks_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !rst_pulse);

   // R8
   irq_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(en || force_on));

   // R11
   irq_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(wclk_en));

   // R9
   wake_from_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> (irq && $past(sleep)));

endmodule

bind wdt_guard wdt_guard_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wclk_en   (wclk_en),
   .en        (en),
   .force_on  (force_on),
   .rst_en    (rst_en),
   .restart   (restart),
   .sleep     (sleep),
   .irq       (irq),
   .rst_pulse (rst_pulse),
   .wake_req  (wake_req)
);

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;

   typedef struct {
      int    kind;   // 0 irq rise, 1 reset pulse, 2 wake pulse
      int    at;
      string req;
   } ev_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wclk_en = 1'b1;
   logic       en = 1'b0;
   logic       force_on = 1'b0;
   logic [3:0] period_sel = 4'd0;
   logic       rst_en = 1'b0;
   logic [1:0] dly_sel = 2'd0;
   logic       restart = 1'b0;
   logic       irq_clr = 1'b0;
   logic       sleep = 1'b0;
   logic       irq, rst_pulse, wake_req;

   int  cyc = 0;
   int  n_chk = 0;
   int  n_fail = 0;
   int  n_rst = 0;
   bit  irq_prev = 1'b0;
   bit  done = 1'b0;
   ev_t exp_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   wdt_guard u_wdt_guard (
      .clk (clk), .rst_n (rst_n), .wclk_en (wclk_en), .en (en),
      .force_on (force_on), .period_sel (period_sel), .rst_en (rst_en),
      .dly_sel (dly_sel), .restart (restart), .irq_clr (irq_clr),
      .sleep (sleep), .irq (irq), .rst_pulse (rst_pulse), .wake_req (wake_req)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic expect_ev(input int kind, input int at, input string req);
      ev_t e;
      e.kind = kind; e.at = at; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic got(input int kind);
      ev_t e;
      n_chk++;
      if (exp_q.size() == 0) begin
         n_fail++;
         $display("FAIL R4 unexpected event kind=%0d at edge %0d expected none", kind, cyc);
      end else begin
         e = exp_q.pop_front();
         if (e.kind != kind || e.at != cyc) begin
            n_fail++;
            $display("FAIL %s actual kind=%0d edge=%0d expected kind=%0d edge=%0d",
                     e.req, kind, cyc, e.kind, e.at);
         end
      end
   endtask

   // Monitor: compares produced events against the scoreboard queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq && !irq_prev) got(0);
         if (wake_req) got(2);
         if (rst_pulse) begin
            got(1);
            n_rst++;
         end
         irq_prev = irq;
      end
   end

   task automatic do_restart(output int e0);
      restart = 1'b1;
      e0 = cyc + 1;
      @(negedge clk);
      restart = 1'b0;
   endtask

   task automatic wait_until(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic quiet();
      en = 1'b0; force_on = 1'b0; sleep = 1'b0; rst_en = 1'b0; wclk_en = 1'b1;
      @(negedge clk);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int e0, e1, r0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq == 1'b0, "R1 irq after reset", irq, 0);
      chk(rst_pulse == 1'b0, "R1 rst_pulse after reset", rst_pulse, 0);
      chk(wake_req == 1'b0, "R1 wake_req after reset", wake_req, 0);

      // R2/R3/R4: shortest period, interrupt only
      en = 1; period_sel = 0;
      do_restart(e0);
      expect_ev(0, e0 + 16, "R2 period 16");
      wait_until(e0 + 40);
      chk(irq == 1'b1, "R3 irq sticky", irq, 1);
      chk(n_rst == 0, "R4 no reset in irq mode", n_rst, 0);
      quiet();
      chk(irq == 1'b0, "R3 irq cleared", irq, 0);

      // R3: set wins over clear on the same edge
      en = 1;
      do_restart(e0);
      expect_ev(0, e0 + 16, "R3 set-wins time-out");
      wait_until(e0 + 15);
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
      chk(irq == 1'b1, "R3 set wins over clear", irq, 1);
      quiet();

      // R2: period 64
      en = 1; period_sel = 1;
      do_restart(e0);
      expect_ev(0, e0 + 64, "R2 period 64");
      wait_until(e0 + 64);
      quiet();

      // R10: shorten period below current count
      en = 1; period_sel = 2;
      do_restart(e0);
      expect_ev(0, e0 + 101, "R10 shortened period");
      wait_until(e0 + 100);
      period_sel = 0;
      wait_until(e0 + 101);
      quiet();

      // R5/R6: delay 3, state returns to initial after the pulse
      en = 1; rst_en = 1; period_sel = 0; dly_sel = 3;
      r0 = n_rst;
      do_restart(e0);
      expect_ev(0, e0 + 16, "R5 time-out before delay 3");
      expect_ev(1, e0 + 19, "R5 reset after delay 3");
      expect_ev(0, e0 + 35, "R6 counter restarted by reset");
      wait_until(e0 + 20);
      chk(rst_pulse == 1'b0, "R5 pulse one cycle", rst_pulse, 0);
      wait_until(e0 + 35);
      en = 1'b0;
      wait_until(e0 + 80);
      chk(n_rst == r0 + 1, "R8 disable drops open window", n_rst - r0, 1);
      quiet();

      // R5/R6: delay 18
      en = 1; rst_en = 1; period_sel = 1; dly_sel = 2;
      do_restart(e0);
      expect_ev(0, e0 + 64, "R5 time-out before delay 18");
      expect_ev(1, e0 + 82, "R5 reset after delay 18");
      wait_until(e0 + 82);
      chk(irq == 1'b0, "R6 reset clears irq", irq, 0);
      quiet();

      // R7: restart inside the 130 window
      en = 1; rst_en = 1; period_sel = 0; dly_sel = 1;
      do_restart(e0);
      expect_ev(0, e0 + 16, "R7 first time-out");
      wait_until(e0 + 60);
      do_restart(e1);
      expect_ev(1, e1 + 146, "R7 reset after restart, delay 130");
      wait_until(e1 + 146);
      quiet();

      // R5: delay 1026
      en = 1; rst_en = 1; period_sel = 0; dly_sel = 0;
      do_restart(e0);
      expect_ev(0, e0 + 16, "R5 time-out before delay 1026");
      expect_ev(1, e0 + 1042, "R5 reset after delay 1026");
      wait_until(e0 + 1042);
      quiet();

      // R8: force_on overrides en low
      en = 0; force_on = 1; period_sel = 0;
      do_restart(e0);
      expect_ev(0, e0 + 16, "R8 forced enable");
      wait_until(e0 + 16);
      quiet();

      // R8: disabled watchdog never times out
      do_restart(e0);
      wait_until(e0 + 300);
      chk(irq == 1'b0, "R8 disabled no time-out", irq, 0);

      // R8: disabling holds the counter at zero
      en = 1;
      do_restart(e0);
      expect_ev(0, e0 + 46, "R8 counter zeroed while disabled");
      wait_until(e0 + 10);
      en = 0;
      wait_until(e0 + 30);
      en = 1;
      wait_until(e0 + 46);
      quiet();

      // R9: wake request during sleep
      en = 1; sleep = 1; period_sel = 0;
      do_restart(e0);
      expect_ev(0, e0 + 16, "R9 time-out in sleep");
      expect_ev(2, e0 + 16, "R9 wake pulse");
      wait_until(e0 + 17);
      chk(wake_req == 1'b0, "R9 wake one cycle", wake_req, 0);
      quiet();

      // R11: half-rate tick
      en = 1; period_sel = 0; wclk_en = 0;
      do_restart(e0);
      expect_ev(0, e0 + 31, "R11 half-rate tick");
      while (cyc < e0 + 31) begin
         wclk_en = ((cyc - e0) % 2 == 0);
         @(negedge clk);
      end
      quiet();

      // R2: out-of-range select means longest period
      en = 1; period_sel = 4'd15;
      do_restart(e0);
      wait_until(e0 + 400);
      chk(irq == 1'b0, "R2 select 15 uses longest period", irq, 0);
      quiet();

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule